// File: doc/BRIEF.md
# Priority pin-function port multiplexer

This block controls an eight-pin general-purpose port. Three sources can own each pin. In order of strength they are analog-bus routing, a dedicated peripheral function and ordinary digital I/O. Software configures the port through a small register bank. The bank holds a per-pair analog enable, plus per-pin pull-up, output, direction and function-enable bits. The block resolves which source owns each pin and drives the pad controls: output value, output enable and pull-up enable. It also drives a one-hot link from each pin to one of four analog bus lines, and it returns the sampled pad levels through the read path.

When a pair of pins is in analog mode, the pull-up, output and direction bits no longer act as digital controls. The pull-up bit becomes the connect switch. A two-bit line code selects the bus line. An odd pin takes its code from the output register, and an even pin takes its code from the direction register. Each function-enable bit hands one pin to a fixed peripheral signal: UART receive and transmit on pins 7 and 6, two synchronous-serial signals on pins 5 and 4, a 32 kHz clock on pin 3, the CPU clock on pin 2, and two PWM outputs on pins 1 and 0. That peripheral then supplies the pin's value and drive enable on the `funcOut` and `funcOe` bits with the same index.

Top module: `portMux`

## Requirements
- R1: A synchronous reset clears every register to 0. Afterwards, all register reads at addresses 0 to 4 return 0, and padOut, padOe, padPullup and anaConn are all 0.
- R2: A pin that is neither analog nor function-owned is digital I/O. Its padOe equals its direction bit (address 3) and its padOut equals its output bit (address 2).
- R3: padPullup of a pin is 1 only when the pin is digital I/O, its direction bit is 0 and its pull-up bit (address 1) is 1. In every other case padPullup is 0.
- R4: A pin that is not analog and has its function-enable bit (address 4) set takes padOut from funcOut and padOe from funcOe, at the same bit index.
- R5: Analog-enable bit p (address 0) puts pins 2p and 2p+1 into analog mode, even when their function bits are set. An analog pin has padOut, padOe and padPullup all at 0.
- R6: An analog odd pin x with pull-up bit 1 drives anaConn bit 4x+c high, where c is output bits [x, x-1] (x is the MSB). All other anaConn bits of that pin are 0.
- R7: An analog even pin x with pull-up bit 1 drives anaConn bit 4x+c high, where c is direction bits [x+1, x] (x+1 is the MSB).
- R8: An analog pin whose pull-up bit is 0 drives all four of its anaConn bits to 0 (high impedance). A pin that is not analog never drives an anaConn bit.
- R9: A read at address 5 returns padIn, with the bits of analog pins forced to 0.
- R10: A write with wrEn high takes effect at the next rising clock edge. Addresses 0 to 4 read back the stored values, and the analog enable reads in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address: 0 analog, 1 pull-up, 2 output, 3 direction, 4 function, 5 pad input |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| padIn | input | 8 | Sampled pad levels |
| funcOut | input | 8 | Peripheral output value per pin |
| funcOe | input | 8 | Peripheral drive enable per pin |
| padOut | output | 8 | Pad output value |
| padOe | output | 8 | Pad output enable |
| padPullup | output | 8 | Pad pull-up enable |
| anaConn | output | 32 | Bit 4x+c connects pin x to analog line c |

## Verification
A write becomes visible one rising edge after the strobe. The pad controls and anaConn are combinational from the registers and from funcOut/funcOe, so they are valid in the same cycle as that edge. The read data follows addr with no delay. The bench therefore drives every input on the falling edge. It checks pad outputs at the falling edge after the write edge. It samples reads a short delay after changing addr. For the R10 check, it reads the old value before the write edge and the new value after it.

// File: rtl/portMuxPkg.sv
package portMuxPkg;
  typedef enum logic [2:0] {
    A_ANA  = 3'd0,
    A_PULL = 3'd1,
    A_OUT  = 3'd2,
    A_DIR  = 3'd3,
    A_FUNC = 3'd4,
    A_PIN  = 3'd5
  } regAddrE;

  typedef struct packed {
    logic    wrAna;
    logic    wrPull;
    logic    wrOut;
    logic    wrDir;
    logic    wrFunc;
    regAddrE rdSel;
  } strobeT;
endpackage

// File: rtl/portMuxCtrl.sv
module portMuxCtrl
  import portMuxPkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] addr,
  output strobeT     strb
);
  regAddrE sel;
  assign sel = regAddrE'(addr);

  always_comb begin
    strb        = '0;
    strb.rdSel  = sel;
    strb.wrAna  = wrEn && (sel == A_ANA);
    strb.wrPull = wrEn && (sel == A_PULL);
    strb.wrOut  = wrEn && (sel == A_OUT);
    strb.wrDir  = wrEn && (sel == A_DIR);
    strb.wrFunc = wrEn && (sel == A_FUNC);
  end

  // p_one_write_r10: at most one register is written per cycle
  always_comb begin
    a_one_write_r10: assert ($onehot0({strb.wrAna, strb.wrPull, strb.wrOut,
                                       strb.wrDir, strb.wrFunc}));
  end
endmodule

// File: rtl/portMuxDatapath.sv
module portMuxDatapath
  import portMuxPkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobeT                        strb,
  input  logic [NUM_PINS-1:0]           wrData,
  input  logic [NUM_PINS-1:0]           padIn,
  input  logic [NUM_PINS-1:0]           funcOut,
  input  logic [NUM_PINS-1:0]           funcOe,
  output logic [NUM_PINS-1:0]           rdData,
  output logic [NUM_PINS-1:0]           padOut,
  output logic [NUM_PINS-1:0]           padOe,
  output logic [NUM_PINS-1:0]           padPullup,
  output logic [NUM_PINS*(1<<SEL_W)-1:0] anaConn
);
  localparam int PAIRS     = NUM_PINS / 2;
  localparam int NUM_LINES = 1 << SEL_W;

  logic [PAIRS-1:0]    anaReg;
  logic [NUM_PINS-1:0] pullReg, outReg, dirReg, funcReg;
  logic [NUM_PINS-1:0] pinAna;

  always_ff @(posedge clk) begin
    if (rst) begin
      anaReg  <= '0;
      pullReg <= '0;
      outReg  <= '0;
      dirReg  <= '0;
      funcReg <= '0;
    end else begin
      if (strb.wrAna)  anaReg  <= wrData[PAIRS-1:0];
      if (strb.wrPull) pullReg <= wrData;
      if (strb.wrOut)  outReg  <= wrData;
      if (strb.wrDir)  dirReg  <= wrData;
      if (strb.wrFunc) funcReg <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SEL_W-1:0] lineSel;
    logic             isAna, isFunc;

    if (i % 2 == 1) begin : g_odd
      assign lineSel = outReg[i -: SEL_W];
    end else begin : g_even
      assign lineSel = dirReg[i+1 -: SEL_W];
    end

    assign isAna     = anaReg[i/2];
    assign isFunc    = !isAna && funcReg[i];
    assign pinAna[i] = isAna;

    always_comb begin
      padOut[i]    = 1'b0;
      padOe[i]     = 1'b0;
      padPullup[i] = 1'b0;
      anaConn[i*NUM_LINES +: NUM_LINES] = '0;
      if (isAna) begin
        if (pullReg[i]) anaConn[i*NUM_LINES + int'(lineSel)] = 1'b1;
      end else if (isFunc) begin
        padOut[i] = funcOut[i];
        padOe[i]  = funcOe[i];
      end else begin
        padOut[i]    = outReg[i];
        padOe[i]     = dirReg[i];
        padPullup[i] = pullReg[i] && !dirReg[i];
      end
    end

    p_ana_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      isAna |-> (!padOe[i] && !padPullup[i] && !padOut[i]));
    p_conn_onehot_r6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(anaConn[i*NUM_LINES +: NUM_LINES]));
    p_conn_gate_r8: assert property (@(posedge clk) disable iff (rst)
      (|anaConn[i*NUM_LINES +: NUM_LINES]) |-> (isAna && pullReg[i]));
    p_pull_input_r3: assert property (@(posedge clk) disable iff (rst)
      padPullup[i] |-> !padOe[i]);
    p_digital_r2: assert property (@(posedge clk) disable iff (rst)
      (!isAna && !funcReg[i]) |-> (padOe[i] == dirReg[i]));
  end

  always_comb begin
    unique case (strb.rdSel)
      A_ANA:   rdData = {{(NUM_PINS-PAIRS){1'b0}}, anaReg};
      A_PULL:  rdData = pullReg;
      A_OUT:   rdData = outReg;
      A_DIR:   rdData = dirReg;
      A_FUNC:  rdData = funcReg;
      A_PIN:   rdData = padIn & ~pinAna;
      default: rdData = '0;
    endcase
  end

  p_write_out_r10: assert property (@(posedge clk) disable iff (rst)
    strb.wrOut |=> (outReg == $past(wrData)));
  p_write_func_r10: assert property (@(posedge clk) disable iff (rst)
    strb.wrFunc |=> (funcReg == $past(wrData)));
endmodule

// File: rtl/portMux.sv
module portMux
  import portMuxPkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wrEn,
  input  logic [2:0]                     addr,
  input  logic [NUM_PINS-1:0]            wrData,
  output logic [NUM_PINS-1:0]            rdData,
  input  logic [NUM_PINS-1:0]            padIn,
  input  logic [NUM_PINS-1:0]            funcOut,
  input  logic [NUM_PINS-1:0]            funcOe,
  output logic [NUM_PINS-1:0]            padOut,
  output logic [NUM_PINS-1:0]            padOe,
  output logic [NUM_PINS-1:0]            padPullup,
  output logic [NUM_PINS*(1<<SEL_W)-1:0] anaConn
);
  strobeT strb;

  portMuxCtrl u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  portMuxDatapath #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .wrData    (wrData),
    .padIn     (padIn),
    .funcOut   (funcOut),
    .funcOe    (funcOe),
    .rdData    (rdData),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullup (padPullup),
    .anaConn   (anaConn)
  );
endmodule

// File: tb/portMux_tb.sv
module portMux_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [7:0]  padIn = '0;
  logic [7:0]  funcOut = '0;
  logic [7:0]  funcOe = '0;
  logic [7:0]  padOut, padOe, padPullup;
  logic [31:0] anaConn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  portMux u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .funcOut(funcOut), .funcOe(funcOe),
    .padOut(padOut), .padOe(padOe), .padPullup(padPullup), .anaConn(anaConn)
  );

  typedef struct packed {
    logic [7:0] ana, pull, out, dir, func, fOut, fOe;
    logic [7:0] expOut, expOe, expPu;
  } vecT;

  localparam vecT VEC [4] = '{
    '{8'h00, 8'hFF, 8'hA5, 8'h0F, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h0F, 8'hF0},
    '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h0C, 8'hFF, 8'h04, 8'h0C, 8'h04, 8'hF3},
    '{8'h02, 8'h00, 8'hFF, 8'hFF, 8'h0C, 8'hFF, 8'hFF, 8'hF3, 8'hF3, 8'h00},
    '{8'h09, 8'hFF, 8'h00, 8'h00, 8'h30, 8'h10, 8'h30, 8'h10, 8'h30, 8'h0C}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic setAll(input logic [7:0] ana, pull, out, dir, func);
    wr(3'd0, ana); wr(3'd1, pull); wr(3'd2, out); wr(3'd3, dir); wr(3'd4, func);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      check("R1 reg", {24'h0, r}, 32'h0);
    end
    check("R1 padOut", {24'h0, padOut}, 32'h0);
    check("R1 padOe", {24'h0, padOe}, 32'h0);
    check("R1 padPullup", {24'h0, padPullup}, 32'h0);
    check("R1 anaConn", anaConn, 32'h0);

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < 4; v++) begin
      setAll(VEC[v].ana, VEC[v].pull, VEC[v].out, VEC[v].dir, VEC[v].func);
      funcOut = VEC[v].fOut; funcOe = VEC[v].fOe;
      #1;
      check("R2/R4/R5 padOut", {24'h0, padOut}, {24'h0, VEC[v].expOut});
      check("R2/R4/R5 padOe", {24'h0, padOe}, {24'h0, VEC[v].expOe});
      check("R3 padPullup", {24'h0, padPullup}, {24'h0, VEC[v].expPu});
    end
    funcOut = '0; funcOe = '0;

    // R6 R7: pair 0, every code
    for (int c = 0; c < 4; c++) begin
      setAll(8'h01, 8'h03, 8'(c), 8'(3 - c), 8'h00);
      #1;
      check("R6/R7 pair0 conn", anaConn, (32'h1 << (4 + c)) | (32'h1 << (3 - c)));
    end
    // R8: pin1 pull-up off, so pin1 is high impedance
    setAll(8'h01, 8'h01, 8'h03, 8'h02, 8'h00);
    #1;
    check("R8 pin1 highZ", anaConn, 32'h1 << 2);
    // R6 R7: pair 3 (pin7 line3, pin6 line0)
    setAll(8'h08, 8'hC0, 8'hC0, 8'h00, 8'h00);
    #1;
    check("R6/R7 pair3 conn", anaConn, 32'h8100_0000);
    // R8: no analog mode, so no connection even with pull-ups on
    setAll(8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00);
    #1;
    check("R8 no ana conn", anaConn, 32'h0);

    // R9 pad readback
    padIn = 8'hFF;
    wr(3'd0, 8'h01);
    rd(3'd5, r);
    check("R9 ana masked", {24'h0, r}, 32'h0000_00FC);
    wr(3'd0, 8'h00);
    rd(3'd5, r);
    check("R9 plain", {24'h0, r}, 32'h0000_00FF);

    // R10 write timing and readback
    wr(3'd4, 8'h00);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'd4; wrData = 8'h5A;
    #1;
    check("R10 before edge", {24'h0, rdData}, 32'h0);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    check("R10 after edge", {24'h0, rdData}, 32'h0000_005A);
    wr(3'd0, 8'hFF);
    rd(3'd0, r);
    check("R10 ana width", {24'h0, r}, 32'h0000_000F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule